// File: doc/BRIEF.md
# Triggered Sample Sequence Player

This block is the controller of a small playback path. A fixed recording of 4096 sixteen-bit samples sits in an external read-only memory with a one-cycle synchronous read. The memory has output-only data lines and no write or read/write control. The controller idles until a sensor trigger rises. It then sweeps the memory once, from address 0 to address 4095, and hands every word it reads to a digital-to-analog converter through a load strobe. After the last word it goes back to waiting.

A trigger that is still high when the sweep ends does not start a second sweep. Trigger activity during a sweep is ignored. The converter data port is forced to zero whenever no load is being presented, so the converter sees nothing while the block is idle.

Top module: `msg_player`

## Requirements
- R1: During and straight after a synchronous active-high reset, `mem_rd_en_o` is 0, `mem_addr_o` is 0, `dac_load_o` is 0 and `dac_word_o` is 0.
- R2: While idle, and with no rising trigger edge, `mem_rd_en_o` and `dac_load_o` stay 0.
- R3: A rising trigger edge (sampled low, then sampled high at the next clock) seen while idle starts a sweep. `mem_rd_en_o` is 1 in the cycle after the first high sample, with `mem_addr_o` = 0.
- R4: During a sweep `mem_rd_en_o` is 1 on exactly 4096 consecutive cycles, and `mem_addr_o` runs 0, 1, 2, ..., 4095, one step per cycle.
- R5: `dac_load_o` is 1 exactly in the cycle after each cycle with `mem_rd_en_o` = 1. While it is 1, `dac_word_o` carries the memory word returned for the previous cycle's address, so the loaded words are memory[0] through memory[4095] in order.
- R6: `dac_word_o` is 0 in every cycle where `dac_load_o` is 0.
- R7: In the cycle after address 4095 is read, `mem_rd_en_o` is 0 and `mem_addr_o` is back at 0. The block is idle again.
- R8: A trigger held high through the end of a sweep does not start another sweep. The trigger must be seen low and then high again.
- R9: Trigger edges that arrive during a sweep, including one during the read of address 4095, neither restart nor extend that sweep.
- R10: A trigger that is already high when reset is released does not start a sweep until it has been seen low.
- R11: Reset asserted during a sweep stops it. In the next cycle the outputs are in the R1 state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| play_trig_i | input | 1 | Sensor trigger; a rising edge starts a sweep |
| mem_addr_o | output | ADDR_W (12) | Read address to the sample memory |
| mem_rd_en_o | output | 1 | Read enable to the sample memory |
| mem_rdata_i | input | DATA_W (16) | Memory read data, valid one cycle after the enable |
| dac_load_o | output | 1 | Converter load strobe |
| dac_word_o | output | DATA_W (16) | Sample presented to the converter, zero when not loading |

## Verification
The bench builds the block with its default widths, ADDR_W = 12 and DATA_W = 16. This makes every sweep the full 4096 reads, so the count of enables and loads can be checked against the exact figure, and the final address 4095 and the return to idle can be seen directly. One sweep costs about 4100 cycles, which leaves room for several trigger shapes: a one-cycle pulse, a short pulse, a trigger held past the end of the sweep, and retriggers in the middle and at the last address. Each of these runs to completion within the cycle limit. The memory model returns a computed, address-dependent pattern, so an off-by-one in address or in load timing shows up as a data mismatch.

// File: rtl/msgp_pkg.sv
package msgp_pkg;

    localparam int DEF_ADDR_W = 12;
    localparam int DEF_DATA_W = 16;

    typedef enum logic {
        ST_WAIT = 1'b0,
        ST_PLAY = 1'b1
    } play_state_e;

    function automatic int last_index(input int aw);
        return (1 << aw) - 1;
    endfunction

endpackage

// File: rtl/msgp_trig_edge.sv
module msgp_trig_edge (
    input  logic clk,
    input  logic rst,
    input  logic trig_i,
    output logic rise_o
);
    logic trig_q;

    // History resets high: a trigger held through reset is not an edge (R10)
    always_ff @(posedge clk) begin
        if (rst) trig_q <= 1'b1;
        else     trig_q <= trig_i;
    end

    assign rise_o = trig_i & ~trig_q;

    assert_rise_needs_low_R10: assert property (@(posedge clk) disable iff (rst)
        rise_o |-> !$past(trig_i) || $past(rst));
endmodule

// File: rtl/msgp_addr_ctr.sv
module msgp_addr_ctr #(
    parameter int ADDR_W = msgp_pkg::DEF_ADDR_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear_i,
    input  logic              step_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              last_o
);
    localparam int              LastIdx = msgp_pkg::last_index(ADDR_W);
    localparam logic [ADDR_W-1:0] LAST  = LastIdx[ADDR_W-1:0];
    localparam logic [ADDR_W-1:0] ONE   = {{(ADDR_W-1){1'b0}}, 1'b1};

    logic [ADDR_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst || clear_i) addr_q <= '0;
        else if (step_i)    addr_q <= addr_q + ONE;
    end

    assign addr_o = addr_q;
    assign last_o = (addr_q == LAST);

    assert_addr_step_R4: assert property (@(posedge clk) disable iff (rst)
        step_i && !clear_i |=> addr_q == $past(addr_q) + ONE);

    assert_addr_clear_R7: assert property (@(posedge clk) disable iff (rst)
        clear_i |=> addr_q == '0);
endmodule

// File: rtl/msgp_ctrl.sv
module msgp_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic rise_i,
    input  logic last_i,
    output logic active_o,
    output logic step_o,
    output logic clear_o
);
    import msgp_pkg::*;

    play_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: if (rise_i) state_d = ST_PLAY;
            ST_PLAY: if (last_i) state_d = ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_WAIT;
        else     state_q <= state_d;
    end

    assign active_o = (state_q == ST_PLAY);
    assign step_o   = active_o & ~last_i;
    assign clear_o  = active_o & last_i;

    assert_idle_holds_R2: assert property (@(posedge clk) disable iff (rst)
        !active_o && !rise_i |=> !active_o);

    assert_sweep_continues_R9: assert property (@(posedge clk) disable iff (rst)
        active_o && !last_i |=> active_o);

    assert_sweep_ends_R7: assert property (@(posedge clk) disable iff (rst)
        active_o && last_i |=> !active_o);
endmodule

// File: rtl/msgp_dac_stage.sv
module msgp_dac_stage #(
    parameter int DATA_W = msgp_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_en_i,
    input  logic [DATA_W-1:0] rdata_i,
    output logic              load_o,
    output logic [DATA_W-1:0] word_o
);
    logic load_q;

    // Memory data returns one cycle after the enable; the strobe follows it
    always_ff @(posedge clk) begin
        if (rst) load_q <= 1'b0;
        else     load_q <= rd_en_i;
    end

    assign load_o = load_q;
    assign word_o = load_q ? rdata_i : '0;
endmodule

// File: rtl/msg_player.sv
module msg_player #(
    parameter int ADDR_W = msgp_pkg::DEF_ADDR_W,
    parameter int DATA_W = msgp_pkg::DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              play_trig_i,
    output logic [ADDR_W-1:0] mem_addr_o,
    output logic              mem_rd_en_o,
    input  logic [DATA_W-1:0] mem_rdata_i,
    output logic              dac_load_o,
    output logic [DATA_W-1:0] dac_word_o
);
    logic trig_rise;
    logic at_last;
    logic active;
    logic step;
    logic clear;

    msgp_trig_edge u_edge (
        .clk    (clk),
        .rst    (rst),
        .trig_i (play_trig_i),
        .rise_o (trig_rise)
    );

    msgp_ctrl u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .rise_i   (trig_rise),
        .last_i   (at_last),
        .active_o (active),
        .step_o   (step),
        .clear_o  (clear)
    );

    msgp_addr_ctr #(.ADDR_W(ADDR_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .clear_i (clear),
        .step_i  (step),
        .addr_o  (mem_addr_o),
        .last_o  (at_last)
    );

    assign mem_rd_en_o = active;

    msgp_dac_stage #(.DATA_W(DATA_W)) u_dac (
        .clk     (clk),
        .rst     (rst),
        .rd_en_i (active),
        .rdata_i (mem_rdata_i),
        .load_o  (dac_load_o),
        .word_o  (dac_word_o)
    );

    assert_sweep_starts_at_zero_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_rd_en_o) |-> mem_addr_o == '0);

    assert_load_follows_read_R5: assert property (@(posedge clk) disable iff (rst)
        mem_rd_en_o |=> dac_load_o);

    assert_load_only_after_read_R5: assert property (@(posedge clk) disable iff (rst)
        dac_load_o |-> $past(mem_rd_en_o));

    assert_quiet_when_unloaded_R6: assert property (@(posedge clk) disable iff (rst)
        !mem_rd_en_o && !$past(mem_rd_en_o) |-> dac_word_o == '0);
endmodule

// File: tb/msg_player_tb_top.sv
module msg_player_tb_top;
    localparam int AW = 12;
    localparam int DW = 16;
    localparam int NS = 1 << AW;
    localparam int WIN = NS + 100;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trig = 1'b0;
    logic [AW-1:0] addr;
    logic          rd_en;
    logic [DW-1:0] rdata = '0;
    logic          load;
    logic [DW-1:0] word;

    int n_run  = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    msg_player #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .play_trig_i (trig),
        .mem_addr_o  (addr),
        .mem_rd_en_o (rd_en),
        .mem_rdata_i (rdata),
        .dac_load_o  (load),
        .dac_word_o  (word)
    );

    function automatic logic [DW-1:0] rom_word(input int a);
        logic [15:0] x;
        x = 16'(a * 40503 + 11133);
        return x ^ {x[7:0], x[15:8]} ^ 16'(a);
    endfunction

    // Synchronous read-only memory model, one cycle latency
    always_ff @(posedge clk) begin
        if (rd_en) rdata <= rom_word(int'(addr));
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // fields: pulse length, retrigger iteration (0 = none), expected reads
    localparam logic [47:0] SCEN [5] = '{
        {16'd1,    16'd0,    16'd4096},
        {16'd3,    16'd0,    16'd4096},
        {16'd5000, 16'd0,    16'd4096},
        {16'd2,    16'd100,  16'd4096},
        {16'd2,    16'd4095, 16'd4096}
    };

    task automatic run_sweep(input int pulse, input int repulse, input int exp_n);
        int en_n = 0, ld_n = 0, addr_bad = 0, data_bad = 0, quiet_bad = 0;
        bit first_ok = 1'b0, end_ok = 1'b0;
        @(negedge clk);
        trig = 1'b1;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (rd_en) begin
                if (int'(addr) != en_n) addr_bad++;
                en_n++;
            end
            if (load) begin
                if (word != rom_word(ld_n)) data_bad++;
                ld_n++;
            end else if (word != '0) quiet_bad++;
            if (i == 0) first_ok = rd_en && (addr == '0);
            if (i == NS) end_ok = !rd_en && (addr == '0);
            if (i + 1 == pulse) trig = 1'b0;
            if (repulse != 0 && i == repulse) trig = 1'b1;
            if (repulse != 0 && i == repulse + 2) trig = 1'b0;
        end
        check(first_ok, "R3 sweep start at address 0", int'(rd_en), 1);
        check(en_n == exp_n, "R4 read enable count", en_n, exp_n);
        check(addr_bad == 0, "R4 address sequence mismatches", addr_bad, 0);
        check(ld_n == exp_n, "R5 load count", ld_n, exp_n);
        check(data_bad == 0, "R5 loaded data mismatches", data_bad, 0);
        check(quiet_bad == 0, "R6 nonzero data without load", quiet_bad, 0);
        check(end_ok, "R7 idle after address 4095", int'(rd_en), 0);
        if (pulse > WIN) check(en_n == exp_n, "R8 held trigger no restart", en_n, exp_n);
        if (repulse != 0) check(en_n == exp_n, "R9 retrigger ignored", en_n, exp_n);
        trig = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int busy;
        // R1: reset state
        repeat (3) @(negedge clk);
        check(!rd_en && !load && addr == '0 && word == '0, "R1 reset outputs", int'(rd_en), 0);
        rst = 1'b0;
        @(negedge clk);
        check(!rd_en && !load && addr == '0 && word == '0, "R1 outputs after reset", int'(load), 0);

        // R2: idle with trigger low
        busy = 0;
        for (int i = 0; i < 50; i++) begin
            @(negedge clk);
            if (rd_en || load || word != '0) busy++;
        end
        check(busy == 0, "R2 idle cycles with activity", busy, 0);

        // Table of trigger scenarios
        for (int s = 0; s < 5; s++)
            run_sweep(int'(SCEN[s][47:32]), int'(SCEN[s][31:16]), int'(SCEN[s][15:0]));

        // R10: trigger high across reset release
        trig = 1'b1;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        busy = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rd_en) busy++;
        end
        check(busy == 0, "R10 held trigger after reset", busy, 0);
        trig = 1'b0;
        @(negedge clk);
        trig = 1'b1;
        @(negedge clk);
        check(rd_en == 1'b1, "R10 start after low then high", int'(rd_en), 1);

        // R11: reset in the middle of a sweep
        trig = 1'b0;
        repeat (200) @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check(!rd_en && !load && addr == '0 && word == '0, "R11 reset aborts sweep", int'(addr), 0);
        rst = 1'b0;
        busy = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (rd_en || load) busy++;
        end
        check(busy == 0, "R11 stays idle after abort", busy, 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule